// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address made of a segment number and an offset into a physical address. It holds a small table of segment descriptors in its own registers. Each descriptor carries a base address, a length limit, a present flag and three permission flags: read, write and execute. A separate length register sets how many leading table entries count as legal. Software loads descriptors through a plain write port and sets the length register through a second write port.

A lookup enters on a valid/ready request channel. It carries the segment number, the offset and the access type. One cycle later the result is held on a valid/ready response channel. The result is either the base plus the offset, or a trap code that gives the first rule the access broke. The response is a single register stage. A new request is taken whenever that stage is empty or is being drained in the same cycle. If the consumer holds `rsp_ready` low, a response already presented stays unchanged and `req_ready` stays low. No request is lost or reordered.

Top module: `seg_xlate`

## Requirements
- R1: After reset the response channel is empty (`rsp_valid` 0, `req_ready` 1), the length register is 0 and every table entry is not present.
- R2: A request whose segment number is not strictly less than the length register gets trap code 1 (out of range). Length values above SEG_CNT are stored as SEG_CNT.
- R3: A request to an in-range entry whose present flag is 0 gets trap code 2 (absent).
- R4: A request whose offset is greater than or equal to the entry's limit gets trap code 3 (beyond limit).
- R5: Access type codes are 0 read, 1 write and 2 execute. They need permission bit 0, 1 and 2 of the entry respectively. Code 3 is never permitted. A refused access gets trap code 4 (permission).
- R6: A request that breaks no rule gets trap code 0 and physical address base + offset, modulo 2^PA_W. Any trapped response carries address 0.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` high) is presented with `rsp_valid` high immediately after that edge.
- R8: `req_ready` is high exactly when the response stage is empty or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and unchanged.
- R9: A table write or length write in the same cycle as an accepted lookup does not affect that lookup, which sees the old contents. Later lookups see the new contents.
- R10: When several rules are broken, the trap code gives the first one in the order range, absent, limit, permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table entry write enable |
| tbl_idx | input | SEG_W | Entry index to write |
| tbl_base | input | PA_W | Base address for the entry |
| tbl_limit | input | OFF_W | Segment length for the entry |
| tbl_present | input | 1 | Present flag for the entry |
| tbl_perm | input | 3 | Permission flags: bit 0 read, bit 1 write, bit 2 execute |
| len_we | input | 1 | Length register write enable |
| len_val | input | SEG_W+1 | New length register value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_seg | input | SEG_W | Requested segment number |
| req_off | input | OFF_W | Requested offset |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_paddr | output | PA_W | Physical address, 0 when trapped |
| rsp_trap | output | 3 | Trap code: 0 none, 1 range, 2 absent, 3 limit, 4 permission |

## Verification
`req_ready` depends only on the current state and `rsp_ready`, so it is due in the same cycle. Every translation result is due on the response port one edge after the request is accepted. Table and length writes take effect for requests accepted from the following edge onward. The bench drives inputs just after an edge. A behavioural model updates on each rising edge. The bench compares the handshake and the response on every falling edge, so each result is sampled in the cycle it becomes due. Directed lookups check the response at the first falling edge after the accepting edge. Stall tests keep checking over several cycles of back-pressure.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    TRAP_NONE   = 3'd0,
    TRAP_RANGE  = 3'd1,
    TRAP_ABSENT = 3'd2,
    TRAP_BOUND  = 3'd3,
    TRAP_PERM   = 3'd4
  } trap_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_CNT = 8,
  parameter int PA_W    = 20,
  parameter int OFF_W   = 16,
  localparam int SEG_W  = $clog2(SEG_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  input  logic             wr_present,
  input  logic [2:0]       wr_perm,
  input  logic             len_en,
  input  logic [SEG_W:0]   len_in,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFF_W-1:0] rd_limit,
  output logic             rd_present,
  output logic [2:0]       rd_perm,
  output logic [SEG_W:0]   len_q
);

  localparam logic [SEG_W:0] LEN_MAX = (SEG_W+1)'(SEG_CNT);

  logic [PA_W-1:0]  base_q    [SEG_CNT];
  logic [OFF_W-1:0] limit_q   [SEG_CNT];
  logic             present_q [SEG_CNT];
  logic [2:0]       perm_q    [SEG_CNT];

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]    <= '0;
        limit_q[g]   <= '0;
        present_q[g] <= 1'b0;
        perm_q[g]    <= '0;
      end else if (wr_en && (wr_idx == SEG_W'(g))) begin
        base_q[g]    <= wr_base;
        limit_q[g]   <= wr_limit;
        present_q[g] <= wr_present;
        perm_q[g]    <= wr_perm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= (len_in > LEN_MAX) ? LEN_MAX : len_in;
    end
  end

  always_comb begin
    rd_base    = '0;
    rd_limit   = '0;
    rd_present = 1'b0;
    rd_perm    = '0;
    for (int i = 0; i < SEG_CNT; i++) begin
      if (rd_idx == SEG_W'(i)) begin
        rd_base    = base_q[i];
        rd_limit   = limit_q[i];
        rd_present = present_q[i];
        rd_perm    = perm_q[i];
      end
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT = 8,
  parameter int PA_W    = 20,
  parameter int OFF_W   = 16,
  localparam int SEG_W  = $clog2(SEG_CNT)
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       acc,
  input  logic [SEG_W:0]   len,
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W-1:0] limit,
  input  logic             present,
  input  logic [2:0]       perm,
  output trap_e            trap,
  output logic [PA_W-1:0]  paddr
);

  logic perm_ok;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_READ:  perm_ok = perm[PERM_R];
      ACC_WRITE: perm_ok = perm[PERM_W];
      ACC_EXEC:  perm_ok = perm[PERM_X];
      default:   perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if ({1'b0, seg} >= len)  trap = TRAP_RANGE;
    else if (!present)       trap = TRAP_ABSENT;
    else if (off >= limit)   trap = TRAP_BOUND;
    else if (!perm_ok)       trap = TRAP_PERM;
    else                     trap = TRAP_NONE;
  end

  assign paddr = (trap == TRAP_NONE) ? (base + PA_W'(off)) : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT = 8,
  parameter int PA_W    = 20,
  parameter int OFF_W   = 16,
  localparam int SEG_W  = $clog2(SEG_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [SEG_W-1:0] tbl_idx,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [OFF_W-1:0] tbl_limit,
  input  logic             tbl_present,
  input  logic [2:0]       tbl_perm,
  input  logic             len_we,
  input  logic [SEG_W:0]   len_val,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_trap
);

  logic [PA_W-1:0]  e_base;
  logic [OFF_W-1:0] e_limit;
  logic             e_present;
  logic [2:0]       e_perm;
  logic [SEG_W:0]   len_cur;
  trap_e            trap_nxt;
  logic [PA_W-1:0]  paddr_nxt;
  logic             fire;

  seg_table #(.SEG_CNT(SEG_CNT), .PA_W(PA_W), .OFF_W(OFF_W)) table_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tbl_we),
    .wr_idx     (tbl_idx),
    .wr_base    (tbl_base),
    .wr_limit   (tbl_limit),
    .wr_present (tbl_present),
    .wr_perm    (tbl_perm),
    .len_en     (len_we),
    .len_in     (len_val),
    .rd_idx     (req_seg),
    .rd_base    (e_base),
    .rd_limit   (e_limit),
    .rd_present (e_present),
    .rd_perm    (e_perm),
    .len_q      (len_cur)
  );

  seg_check #(.SEG_CNT(SEG_CNT), .PA_W(PA_W), .OFF_W(OFF_W)) check_i (
    .seg     (req_seg),
    .off     (req_off),
    .acc     (req_acc),
    .len     (len_cur),
    .base    (e_base),
    .limit   (e_limit),
    .present (e_present),
    .perm    (e_perm),
    .trap    (trap_nxt),
    .paddr   (paddr_nxt)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_trap  <= TRAP_NONE;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= paddr_nxt;
      rsp_trap  <= trap_nxt;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_CNT = 8,
  parameter int PA_W    = 20,
  parameter int OFF_W   = 16,
  localparam int SEG_W  = $clog2(SEG_CNT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tbl_we,
  input logic [SEG_W-1:0] tbl_idx,
  input logic [PA_W-1:0]  tbl_base,
  input logic [OFF_W-1:0] tbl_limit,
  input logic             tbl_present,
  input logic [2:0]       tbl_perm,
  input logic             len_we,
  input logic [SEG_W:0]   len_val,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEG_W-1:0] req_seg,
  input logic [OFF_W-1:0] req_off,
  input logic [1:0]       req_acc,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [2:0]       rsp_trap
);

  localparam logic [SEG_W:0] LEN_MAX = (SEG_W+1)'(SEG_CNT);

  logic [SEG_W:0] len_seen;
  logic           accepted;

  assign accepted = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      len_seen <= '0;
    else if (len_we) len_seen <= (len_val > LEN_MAX) ? LEN_MAX : len_val;
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

  assert_range_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accepted && ({1'b0, req_seg} >= len_seen) |=> rsp_trap == 3'd1);

  assert_trap_zero_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_trap != 3'd0) |-> rsp_paddr == '0);

  assert_one_cycle_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> rsp_valid);

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_trap));

  assert_no_accept_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !accepted);

  assert_trap_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_trap <= 3'd4);

endmodule

bind seg_xlate seg_xlate_chk #(.SEG_CNT(SEG_CNT), .PA_W(PA_W), .OFF_W(OFF_W)) chk_i (.*);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SEG_CNT    = 8;
  localparam int PA_W       = 20;
  localparam int OFF_W      = 16;
  localparam int SEG_W      = $clog2(SEG_CNT);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tbl_we = 1'b0;
  logic [SEG_W-1:0] tbl_idx = '0;
  logic [PA_W-1:0]  tbl_base = '0;
  logic [OFF_W-1:0] tbl_limit = '0;
  logic             tbl_present = 1'b0;
  logic [2:0]       tbl_perm = '0;
  logic             len_we = 1'b0;
  logic [SEG_W:0]   len_val = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       req_acc = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b1;
  logic [PA_W-1:0]  rsp_paddr;
  logic [2:0]       rsp_trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate #(.SEG_CNT(SEG_CNT), .PA_W(PA_W), .OFF_W(OFF_W)) dut_i (.*);

  // behavioural reference model
  int m_base [SEG_CNT];
  int m_limit[SEG_CNT];
  bit m_pres [SEG_CNT];
  int m_perm [SEG_CNT];
  int m_len;
  bit e_valid;
  int e_paddr;
  int e_trap;

  function automatic int ref_trap(int s, int o, int a);
    bit ok;
    if (s >= m_len) return 1;
    if (!m_pres[s]) return 2;
    if (o >= m_limit[s]) return 3;
    ok = (a < 3) && m_perm[s][a];
    if (!ok) return 4;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_CNT; i++) begin
        m_base[i] = 0; m_limit[i] = 0; m_pres[i] = 0; m_perm[i] = 0;
      end
      m_len = 0; e_valid = 0; e_paddr = 0; e_trap = 0;
    end else begin
      if (req_valid && (!e_valid || rsp_ready)) begin
        e_valid = 1;
        e_trap  = ref_trap(int'(req_seg), int'(req_off), int'(req_acc));
        e_paddr = (e_trap == 0) ? ((m_base[req_seg] + int'(req_off)) % (1 << PA_W)) : 0;
      end else if (rsp_ready) begin
        e_valid = 0;
      end
      if (tbl_we) begin
        m_base[tbl_idx]  = int'(tbl_base);
        m_limit[tbl_idx] = int'(tbl_limit);
        m_pres[tbl_idx]  = tbl_present;
        m_perm[tbl_idx]  = int'(tbl_perm);
      end
      if (len_we) m_len = (int'(len_val) > SEG_CNT) ? SEG_CNT : int'(len_val);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string trap_req(int t);
    case (t)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // per-cycle comparison, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == (!e_valid || rsp_ready), "R8 req_ready", int'(req_ready), int'(!e_valid || rsp_ready));
      chk(rsp_valid == e_valid, "R7 rsp_valid", int'(rsp_valid), int'(e_valid));
      if (e_valid && rsp_valid) begin
        chk(int'(rsp_trap) == e_trap, trap_req(e_trap), int'(rsp_trap), e_trap);
        chk(int'(rsp_paddr) == e_paddr, "R6 paddr", int'(rsp_paddr), e_paddr);
      end
    end
  end

  task automatic write_entry(input int idx, input int base, input int lim, input bit pres, input int perm);
    @(negedge clk); #1;
    tbl_we = 1; tbl_idx = SEG_W'(idx); tbl_base = PA_W'(base);
    tbl_limit = OFF_W'(lim); tbl_present = pres; tbl_perm = 3'(perm);
    @(posedge clk); #1;
    tbl_we = 0;
  endtask

  task automatic write_len(input int v);
    @(negedge clk); #1;
    len_we = 1; len_val = (SEG_W+1)'(v);
    @(posedge clk); #1;
    len_we = 0;
  endtask

  task automatic lookup(input int s, input int o, input int a, input string req,
                        input int exp_trap, input int exp_pa);
    @(negedge clk); #1;
    rsp_ready = 1; req_valid = 1; req_seg = SEG_W'(s); req_off = OFF_W'(o); req_acc = 2'(a);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk(rsp_valid == 1'b1, req, int'(rsp_valid), 1);
    chk(int'(rsp_trap) == exp_trap, req, int'(rsp_trap), exp_trap);
    chk(int'(rsp_paddr) == exp_pa, req, int'(rsp_paddr), exp_pa);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: empty after reset
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    lookup(0, 0, 0, "R1 R2 length zero", 1, 0);
    write_len(8);
    lookup(0, 0, 0, "R1 R3 absent after reset", 2, 0);

    // R6 / R4 / R5 on a descriptor at 4300, length 400, read+write
    write_entry(2, 4300, 400, 1, 3'b011);
    lookup(2, 399, 0, "R6 last byte", 0, 4699);
    lookup(2, 400, 0, "R4 offset at limit", 3, 0);
    lookup(2, 10, 2, "R5 exec refused", 4, 0);
    lookup(2, 10, 3, "R5 reserved access", 4, 0);
    lookup(2, 10, 1, "R5 write allowed", 0, 4310);
    write_entry(4, 4700, 1000, 1, 3'b111);
    lookup(4, 0, 1, "R6 offset zero", 0, 4700);
    lookup(4, 1000, 0, "R4 offset 1000", 3, 0);
    write_entry(6, (1 << PA_W) - 2, 100, 1, 3'b001);
    lookup(6, 5, 0, "R6 wraps modulo", 0, 3);

    // R10 priority
    write_entry(3, 0, 0, 0, 0);
    lookup(3, 50, 3, "R10 absent before limit", 2, 0);
    lookup(2, 500, 2, "R10 limit before permission", 3, 0);
    write_len(4);
    lookup(4, 0, 0, "R2 beyond length", 1, 0);
    lookup(2, 0, 0, "R2 below length", 0, 4300);
    write_len(15);
    lookup(4, 0, 0, "R2 length saturates", 0, 4700);

    // R9: write and lookup to the same entry in one cycle
    @(negedge clk); #1;
    tbl_we = 1; tbl_idx = 2; tbl_base = 100; tbl_limit = 400; tbl_present = 1; tbl_perm = 3'b011;
    len_we = 1; len_val = 0;
    req_valid = 1; req_seg = 2; req_off = 5; req_acc = 0; rsp_ready = 1;
    @(posedge clk); #1;
    tbl_we = 0; len_we = 0; req_valid = 0;
    @(negedge clk);
    chk(int'(rsp_paddr) == 4305, "R9 old contents", int'(rsp_paddr), 4305);
    lookup(2, 5, 0, "R9 new length seen", 1, 0);
    write_len(8);
    lookup(2, 5, 0, "R9 new base seen", 0, 105);

    // R8: back-pressure holds the response
    @(negedge clk); #1;
    rsp_ready = 0; req_valid = 1; req_seg = 4; req_off = 7; req_acc = 0;
    @(posedge clk); #1;
    req_seg = 2; req_off = 9;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && int'(rsp_paddr) == 4707, "R8 held", int'(rsp_paddr), 4707);
      chk(req_ready == 1'b0, "R8 stalled ready", int'(req_ready), 0);
    end
    #1 rsp_ready = 1;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk(int'(rsp_paddr) == 109, "R8 next after drain", int'(rsp_paddr), 109);

    // mixed traffic, compared every cycle by the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); #1;
      req_valid   = ($urandom_range(0, 3) != 0);
      rsp_ready   = ($urandom_range(0, 3) != 0);
      req_seg     = SEG_W'($urandom_range(0, SEG_CNT - 1));
      req_off     = OFF_W'($urandom_range(0, 70));
      req_acc     = 2'($urandom_range(0, 3));
      tbl_we      = ($urandom_range(0, 7) == 0);
      tbl_idx     = SEG_W'($urandom_range(0, SEG_CNT - 1));
      tbl_base    = PA_W'($urandom);
      tbl_limit   = OFF_W'($urandom_range(0, 64));
      tbl_present = ($urandom_range(0, 4) != 0);
      tbl_perm    = 3'($urandom_range(0, 7));
      len_we      = ($urandom_range(0, 31) == 0);
      len_val     = (SEG_W+1)'($urandom_range(0, SEG_CNT + 2));
    end
    @(negedge clk); #1;
    req_valid = 0; tbl_we = 0; len_we = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule